// File: doc/BRIEF.md
# Harvard CPU Core with Tagged Program-Space Operands

This is a 16-bit two-register (A and D) processor core with separate instruction and data memories. The core fetches one instruction per clock from the program port and completes most instructions in that single clock, which is called phase t1. The instruction encoding has no new opcodes. Instead, the top bit of the A register chooses where an M operand lives. When that bit is 0, the operand is in data memory at A[14:0]. When that bit is 1, the operand is in program memory at A[14:0], so code word 0x0123 is reached through the pointer value 0x8123.

A program-space operand costs one extra clock, called phase t2. During t1 the core latches the fetched instruction and holds the PC. In t2 the program port address switches from the PC to A[14:0]. A read, a write or a read-modify-write of that word then happens within t2, and the PC moves on only at the end of t2. Program memory may be a ROM; the core always drives its write strobe, and a ROM simply ignores it. A write to data memory and a write to program memory never fall in the same cycle, so both memories take their write data from one shared bus. The data address is forced to zero in every cycle that is not a data-memory access, so a program pointer held in A never reaches memory-mapped devices.

An instruction that loads A and also jumps takes its jump target from the newly computed A value. With a program-space operand, this gives a one-instruction jump through a pointer table held in code.

Both memory ports are plain synchronous-write, combinational-read ports. They carry no valid/ready handshake, because the core's own phase sequencing paces every access.

Top module: `tagcpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is cleared to 0 and the phase returns to t1. After reset, `pm_addr` is 0 and neither `pm_we` nor `dm_we` is asserted.
- R2: An instruction with bit 15 equal to 0 loads its full 16-bit word into A, completes in one clock and never enters t2.
- R3: A C-instruction has instruction[15]=1, and the core ignores instruction[14:13]. Its fields are:
  - bit 12 selects the M operand instead of A as the ALU y input;
  - bits 11:6 are the ALU controls zx, nx, zy, ny, f, no, in that order;
  - bits 5:3 are the destinations A, D, M;
  - bits 2:0 are the jump-if conditions less-than, equal, greater-than.

  When A[15]=0, a C-instruction completes in one clock. The M operand comes from `dm_rdata` at `dm_addr`=A[14:0], and destination M asserts `dm_we` with the ALU result on `wr_data`.
- R4: `dm_addr` is 0 in every cycle that is not a data-memory access. This covers A-instructions, instructions without an M reference, t1 of a program-space access and all of t2.
- R5: A C-instruction that references M (bit 12 or bit 5:3's M destination set) while A[15]=1 takes two clocks. In t1, `pm_addr` holds the PC and nothing is written. In t2, `pm_addr` is A[14:0]. The PC advances or jumps only at the end of t2.
- R6: In t2, the ALU y input for a program-space operand is `pm_rdata`, that is, program memory at A[14:0].
- R7: In t2, destination M asserts `pm_we` with the ALU result on `wr_data`, to be written at `pm_addr`=A[14:0]. A modify reads and writes back the same word within t2.
- R8: `pm_we` and `dm_we` are never asserted in the same cycle. Both memories take their write data from `wr_data`.
- R9: A C-instruction that has destination A and a taken jump continues at the newly computed A value, not at the old A.
- R10: A taken jump without destination A continues at A[14:0]. A jump that is not taken continues at PC+1. A jump is taken when the result has a selected condition: negative, zero, or positive and nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | 15 | Program port address: the PC in t1, A[14:0] in t2 |
| pm_rdata | input | 16 | Program port read data: the instruction in t1, the operand in t2 |
| pm_we | output | 1 | Program memory write strobe (t2 only) |
| dm_addr | output | 15 | Data memory address, 0 when idle |
| dm_rdata | input | 16 | Data memory read data |
| dm_we | output | 1 | Data memory write strobe |
| wr_data | output | 16 | Write data bus shared by both memories |

## Verification
Two things can fall in the same t2 cycle, and the directed tests provoke both:
- A program-space read that loads A and a jump that uses the loaded value. A pointer-table jump is run, and the next fetch address is judged to be the table entry and not the old pointer.
- The read and the write-back of a program-space modify. An increment of a code word is run, and the judgement rests on three things: the t2 write strobe and data, the program-port address switching for exactly one cycle, and a later read of that word returning the incremented value.

Data-memory runs also confirm that the two write strobes never overlap.

// File: rtl/tagcpu_pkg.sv
package tagcpu_pkg;

  // Decoded control for the instruction currently being executed.
  typedef struct packed {
    logic       is_c;    // compute instruction (not a literal load)
    logic       src_m;   // y operand comes from M instead of A
    logic       use_m;   // instruction reads or writes M
    logic [5:0] alu_op;  // zx nx zy ny f no
    logic       dst_a;
    logic       dst_d;
    logic       dst_m;
    logic [2:0] jmp;     // lt eq gt
  } ctl_t;

endpackage

// File: rtl/tagcpu_decode.sv
module tagcpu_decode
  import tagcpu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] instr,
  output ctl_t              ctl
);
  logic unused_fill;
  assign unused_fill = ^instr[14:13];

  always_comb begin
    ctl.is_c   = instr[WORD_W-1];
    ctl.src_m  = instr[12];
    ctl.alu_op = instr[11:6];
    ctl.dst_a  = instr[5];
    ctl.dst_d  = instr[4];
    ctl.dst_m  = instr[3];
    ctl.jmp    = instr[2:0];
    ctl.use_m  = instr[WORD_W-1] & (instr[12] | instr[3]);
  end
endmodule

// File: rtl/tagcpu_alu.sv
module tagcpu_alu #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] x_in,
  input  logic [WORD_W-1:0] y_in,
  input  logic [5:0]        op,
  output logic [WORD_W-1:0] res,
  output logic              zr,
  output logic              ng
);
  logic [WORD_W-1:0] xa, xb, ya, yb, fo;

  always_comb begin
    xa  = op[5] ? '0 : x_in;
    xb  = op[4] ? ~xa : xa;
    ya  = op[3] ? '0 : y_in;
    yb  = op[2] ? ~ya : ya;
    fo  = op[1] ? (xb + yb) : (xb & yb);
    res = op[0] ? ~fo : fo;
  end

  assign zr = (res == '0);
  assign ng = res[WORD_W-1];
endmodule

// File: rtl/tagcpu_phase.sv
module tagcpu_phase (
  input  logic clk,
  input  logic rst,
  input  logic need_t2,
  output logic in_t2
);
  // One-bit phase: t1 (0) or t2 (1); t2 always lasts exactly one clock.
  always_ff @(posedge clk) begin
    if (rst) in_t2 <= 1'b0;
    else     in_t2 <= need_t2;
  end
endmodule

// File: rtl/tagcpu_branch.sv
module tagcpu_branch #(
  parameter int ADDR_W = 15
) (
  input  logic [2:0]        jmp,
  input  logic              zr,
  input  logic              ng,
  input  logic              is_c,
  input  logic              dst_a,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] a_old,
  input  logic [ADDR_W-1:0] a_new,
  output logic [ADDR_W-1:0] pc_nxt
);
  logic take;

  assign take = is_c & ((jmp[2] & ng) | (jmp[1] & zr) | (jmp[0] & ~ng & ~zr));

  always_comb begin
    if (!take)      pc_nxt = pc_cur + 1'b1;
    else if (dst_a) pc_nxt = a_new;
    else            pc_nxt = a_old;
  end
endmodule

// File: rtl/tagcpu_core.sv
module tagcpu_core
  import tagcpu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  output logic [WORD_W-2:0]   pm_addr,
  input  logic [WORD_W-1:0]   pm_rdata,
  output logic                pm_we,
  output logic [WORD_W-2:0]   dm_addr,
  input  logic [WORD_W-1:0]   dm_rdata,
  output logic                dm_we,
  output logic [WORD_W-1:0]   wr_data
);
  localparam int ADDR_W = WORD_W - 1;

  logic [WORD_W-1:0] a_q, d_q, ir_q;
  logic [ADDR_W-1:0] pc_q, pc_nxt;
  logic              in_t2, need_t2, a_tag, dm_access, done;
  logic [WORD_W-1:0] instr, m_val, y_val, alu_res;
  logic              alu_zr, alu_ng;
  ctl_t              ctl;

  // Instruction comes straight from the port in t1, from the latch in t2.
  assign instr = in_t2 ? ir_q : pm_rdata;

  tagcpu_decode #(.WORD_W(WORD_W)) u_dec (
    .instr (instr),
    .ctl   (ctl)
  );

  assign a_tag     = a_q[WORD_W-1];
  assign need_t2   = ~in_t2 & ctl.use_m & a_tag;
  assign dm_access = ~in_t2 & ctl.use_m & ~a_tag;
  assign done      = ~need_t2;

  assign m_val = in_t2 ? pm_rdata : dm_rdata;
  assign y_val = ctl.src_m ? m_val : a_q;

  tagcpu_alu #(.WORD_W(WORD_W)) u_alu (
    .x_in (d_q),
    .y_in (y_val),
    .op   (ctl.alu_op),
    .res  (alu_res),
    .zr   (alu_zr),
    .ng   (alu_ng)
  );

  tagcpu_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .need_t2 (need_t2),
    .in_t2   (in_t2)
  );

  tagcpu_branch #(.ADDR_W(ADDR_W)) u_br (
    .jmp    (ctl.jmp),
    .zr     (alu_zr),
    .ng     (alu_ng),
    .is_c   (ctl.is_c),
    .dst_a  (ctl.dst_a),
    .pc_cur (pc_q),
    .a_old  (a_q[ADDR_W-1:0]),
    .a_new  (alu_res[ADDR_W-1:0]),
    .pc_nxt (pc_nxt)
  );

  // Port steering
  assign pm_addr = in_t2 ? a_q[ADDR_W-1:0] : pc_q;
  assign pm_we   = in_t2 & ctl.dst_m;
  assign dm_addr = dm_access ? a_q[ADDR_W-1:0] : '0;
  assign dm_we   = dm_access & ctl.dst_m;
  assign wr_data = alu_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      a_q  <= '0;
      d_q  <= '0;
      ir_q <= '0;
    end else begin
      if (need_t2) ir_q <= pm_rdata;
      if (done) begin
        pc_q <= pc_nxt;
        if (!ctl.is_c)     a_q <= instr;
        else if (ctl.dst_a) a_q <= alu_res;
        if (ctl.is_c && ctl.dst_d) d_q <= alu_res;
      end
    end
  end
endmodule

// File: rtl/tagcpu_chk.sv
module tagcpu_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_t2,
  input logic [WORD_W-2:0] pc_q,
  input logic [WORD_W-1:0] a_q,
  input logic [WORD_W-2:0] pm_addr,
  input logic              pm_we,
  input logic [WORD_W-2:0] dm_addr,
  input logic              dm_we
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && !in_t2 && !pm_we && !dm_we));

  // R8
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    !(pm_we && dm_we));

  // R4
  idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
    in_t2 |-> (dm_addr == '0 && !dm_we));

  // R5
  t2_single_chk: assert property (@(posedge clk) disable iff (rst)
    in_t2 |=> !in_t2);

  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_t2) |-> $stable(pc_q));

  // R5
  t2_tag_chk: assert property (@(posedge clk) disable iff (rst)
    in_t2 |-> (a_q[WORD_W-1] && pm_addr == a_q[WORD_W-2:0]));

  // R7
  pm_write_phase_chk: assert property (@(posedge clk) disable iff (rst)
    pm_we |-> in_t2);
endmodule

bind tagcpu_core tagcpu_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_t2   (in_t2),
  .pc_q    (pc_q),
  .a_q     (a_q),
  .pm_addr (pm_addr),
  .pm_we   (pm_we),
  .dm_addr (dm_addr),
  .dm_we   (dm_we)
);

// File: tb/tagcpu_core_test.sv
module tagcpu_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [14:0] pm_addr, dm_addr;
  logic [15:0] pm_rdata, dm_rdata, wr_data;
  logic        pm_we, dm_we;

  logic [15:0] prog [256];
  logic [15:0] dmem [256];
  logic [15:0] prog_init [256];
  logic [15:0] dmem_init [256];

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  tagcpu_core uut (
    .clk      (clk),
    .rst      (rst),
    .pm_addr  (pm_addr),
    .pm_rdata (pm_rdata),
    .pm_we    (pm_we),
    .dm_addr  (dm_addr),
    .dm_rdata (dm_rdata),
    .dm_we    (dm_we),
    .wr_data  (wr_data)
  );

  // Memory models: combinational read, write at the rising edge.
  assign pm_rdata = prog[pm_addr[7:0]];
  assign dm_rdata = dmem[dm_addr[7:0]];

  always @(posedge clk) begin
    if (load) begin
      prog <= prog_init;
      dmem <= dmem_init;
    end else begin
      if (pm_we) prog[pm_addr[7:0]] <= wr_data;
      if (dm_we) dmem[dm_addr[7:0]] <= wr_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      prog_init[i] = 16'h0000;
      dmem_init[i] = 16'h0000;
    end
  endtask

  // Applies reset with memory load; returns at cycle c0 (first fetch visible).
  task automatic start();
    rst  = 1'b1;
    load = 1'b1;
    repeat (2) @(negedge clk);
    load = 1'b0;
    rst  = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_mem();
    start();
    check("R1 pm_addr after reset", 32'(pm_addr), 32'h0);
    check("R1 pm_we after reset", 32'(pm_we), 32'h0);
    check("R1 dm_we after reset", 32'(dm_we), 32'h0);
    check("R4 dm_addr after reset", 32'(dm_addr), 32'h0);
  endtask

  task automatic t_literal();
    clear_mem();
    prog_init[0] = 16'h0005; // @5
    prog_init[1] = 16'hEC10; // D=A
    prog_init[2] = 16'h0064; // @100
    prog_init[3] = 16'hE308; // M=D
    start();
    check("R4 idle dm_addr on literal", 32'(dm_addr), 32'h0);
    step(1);
    check("R2 one-cycle literal pm_addr", 32'(pm_addr), 32'h1);
    step(1);
    check("R2 literal pm_addr c2", 32'(pm_addr), 32'h2);
    check("R3 no write on D=A", 32'(dm_we), 32'h0);
    step(1);
    check("R3 dm_we on M=D", 32'(dm_we), 32'h1);
    check("R3 dm_addr on M=D", 32'(dm_addr), 32'd100);
    check("R2 literal value on bus", 32'(wr_data), 32'h5);
    check("R8 no pm_we with dm_we", 32'(pm_we), 32'h0);
  endtask

  task automatic t_dm_modify();
    clear_mem();
    dmem_init[50] = 16'h0007;
    prog_init[0]  = 16'h0032; // @50
    prog_init[1]  = 16'hFDC8; // M=M+1
    start();
    step(1);
    check("R3 data modify dm_we", 32'(dm_we), 32'h1);
    check("R3 data modify wr_data", 32'(wr_data), 32'h8);
    check("R8 data modify pm_we", 32'(pm_we), 32'h0);
    step(1);
    check("R3 single cycle data modify", 32'(pm_addr), 32'h2);
    check("R3 data memory updated", 32'(dmem[50]), 32'h8);
  endtask

  task automatic t_pm_read();
    clear_mem();
    prog_init[16'h10] = 16'h1234;
    prog_init[0] = 16'h7FF0; // @0x7FF0
    prog_init[1] = 16'hEC50; // D=!A   -> 0x800F
    prog_init[2] = 16'hE7E0; // A=D+1  -> 0x8010
    prog_init[3] = 16'hFC10; // D=M    (program space)
    prog_init[4] = 16'h00C8; // @200
    prog_init[5] = 16'hE308; // M=D
    start();
    step(3);
    check("R5 t1 pm_addr is PC", 32'(pm_addr), 32'h3);
    check("R4 t1 dm_addr idle", 32'(dm_addr), 32'h0);
    check("R5 t1 no dm write", 32'(dm_we), 32'h0);
    step(1);
    check("R5 t2 pm_addr is A", 32'(pm_addr), 32'h10);
    check("R4 t2 dm_addr idle", 32'(dm_addr), 32'h0);
    check("R6 read does not write", 32'(pm_we), 32'h0);
    step(1);
    check("R5 PC advances after t2", 32'(pm_addr), 32'h4);
    check("R4 tagged A not on dm_addr", 32'(dm_addr), 32'h0);
    step(1);
    check("R6 operand from program memory", 32'(wr_data), 32'h1234);
    check("R6 stored to data addr", 32'(dm_addr), 32'd200);
  endtask

  task automatic t_pm_modify();
    clear_mem();
    prog_init[16'h20] = 16'h0041;
    prog_init[0] = 16'h7FE0; // @0x7FE0
    prog_init[1] = 16'hEC50; // D=!A  -> 0x801F
    prog_init[2] = 16'hE7E0; // A=D+1 -> 0x8020
    prog_init[3] = 16'hFDC8; // M=M+1 (program space)
    prog_init[4] = 16'hFC10; // D=M
    prog_init[5] = 16'h00C9; // @201
    prog_init[6] = 16'hE308; // M=D
    start();
    step(3);
    check("R5 t1 modify no pm_we", 32'(pm_we), 32'h0);
    step(1);
    check("R7 t2 pm_we", 32'(pm_we), 32'h1);
    check("R7 t2 address", 32'(pm_addr), 32'h20);
    check("R7 t2 write data", 32'(wr_data), 32'h42);
    check("R8 t2 no dm_we", 32'(dm_we), 32'h0);
    step(1);
    check("R7 program word updated", 32'(prog[16'h20]), 32'h42);
    check("R5 PC after modify", 32'(pm_addr), 32'h4);
    step(3);
    check("R7 readback via store", 32'(wr_data), 32'h42);
    check("R3 store strobe", 32'(dm_we), 32'h1);
  endtask

  task automatic t_jump();
    clear_mem();
    prog_init[16'h30] = 16'h0040;
    prog_init[0]  = 16'h7FCF; // @0x7FCF
    prog_init[1]  = 16'hEC50; // D=!A -> 0x8030
    prog_init[2]  = 16'hE320; // A=D
    prog_init[3]  = 16'hFC27; // A=M;JMP
    prog_init[16'h40] = 16'h0050; // @0x50
    prog_init[16'h41] = 16'hE301; // D;JGT (D negative: not taken)
    prog_init[16'h42] = 16'hE304; // D;JLT (taken)
    start();
    step(4);
    check("R5 jump table read address", 32'(pm_addr), 32'h30);
    step(1);
    check("R9 jump to newly loaded A", 32'(pm_addr), 32'h40);
    step(2);
    check("R10 untaken jump falls through", 32'(pm_addr), 32'h42);
    step(1);
    check("R10 taken jump to A", 32'(pm_addr), 32'h50);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_literal();
    t_dm_modify();
    t_pm_read();
    t_pm_modify();
    t_jump();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule